// File: doc/BRIEF.md
# Banked Data Address Generator

This block forms the 12-bit data-memory address for each instruction of an 8-bit banked-register processor. A short instruction carries an 8-bit file operand and an access bit. The operand is either joined to a 4-bit bank register or folded into a fixed window, called the access bank, that covers the bottom and top of data memory. A two-word move carries the full 12-bit address and bypasses banking. An indirect access takes its address from one of three 12-bit pointer registers.

When the extended mode is on, a short instruction with the access bit clear and an operand below 0x60 does not use the access bank. Its operand becomes an unsigned displacement from the third pointer. Banked accesses, two-word moves and the first two pointers are not affected by the extended mode.

The block holds the three pointers. It applies their post-increment, post-decrement and pre-increment updates at the end of the access cycle. It also decodes the destination bit into a select for the working register. The effective address is combinational; only the pointers are registered.

Top module: `bank_addr_gen`

## Requirements
- R1: With the access bit at 1, no indirect access and no two-word move, the address is the bank register in bits 11:8 and the operand in bits 7:0. This holds whether the extended mode is on or off.
- R2: With the access bit at 0 and the extended mode off, operands 0x00 to 0x5F give addresses 0x000 to 0x05F, and operands 0x60 to 0xFF give addresses 0xF60 to 0xFFF.
- R3: With the extended mode on, the access bit at 0 and the operand at most 0x5F, the address is pointer 2 plus the zero-extended operand, taken modulo 4096.
- R4: With the extended mode on, the access bit at 0 and the operand at 0x60 or above, the upper access-bank mapping of R2 applies unchanged.
- R5: During a two-word move (long_mv_i=1) without an indirect access, the address equals long_addr_i, and the bank register, access bit and operand have no effect.
- R6: An indirect access (ind_en_i=1) takes priority over a two-word move and over direct addressing. ind_op_i selects the mode: 0 reads the pointer unchanged; 1 reads the pointer and then increments it; 2 reads the pointer and then decrements it.
- R7: With ind_op_i=3, the address is the pointer plus 1, and the pointer holds that value after the clock edge.
- R8: With ind_op_i=4, the address is the pointer plus ind_ofs_i sign-extended from 8 bits, and the pointer is unchanged. Codes 5 to 7 behave like code 0.
- R9: Every pointer update wraps within 12 bits, so 0xFFF+1 gives 0x000 and 0x000-1 gives 0xFFF.
- R10: dest_wreg_o is 1 exactly when dest_bit_i is 0.
- R11: Reset clears all pointers to 0. ld_en_i writes ld_val_i into the pointer named by ld_sel_i at the next edge, and this write wins over an auto-update of the same pointer in the same cycle.
- R12: An indirect access changes only the selected pointer. Pointers 0 and 1 are not affected by the extended mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_i | input | 8 | File operand of a short instruction |
| acc_sel_i | input | 1 | 1 = banked, 0 = access bank or indexed |
| bank_i | input | 4 | Bank-select register |
| ext_en_i | input | 1 | Extended-mode enable |
| dest_bit_i | input | 1 | Destination bit of the instruction |
| long_mv_i | input | 1 | Two-word move with full address |
| long_addr_i | input | 12 | Full address of a two-word move |
| ind_en_i | input | 1 | Indirect access this cycle |
| ind_sel_i | input | 2 | Pointer used by the indirect access (0..2) |
| ind_op_i | input | 3 | Indirect mode code (see R6 to R8) |
| ind_ofs_i | input | 8 | Signed offset for mode 4 |
| ld_en_i | input | 1 | Pointer load strobe |
| ld_sel_i | input | 2 | Pointer to load (0..2) |
| ld_val_i | input | 12 | Value to load |
| eff_addr_o | output | 12 | Effective data address |
| dest_wreg_o | output | 1 | 1 = result goes to the working register |
| ptrs_o | output | 36 | Pointer values, pointer k in bits 12k+11:12k |

## Verification
The direct sweep covers the 0x5F/0x60 operand boundary in all four combinations of access bit and extended mode. A design that took the boundary one step off would send operand 0x5F or 0x60 to the wrong region. The indexed case is driven with pointer 2 near the top of memory, so an adder that did not wrap would give an address out of range. Every indirect mode is run on pointers 0x000, 0x7FF and 0xFFF, and the offset mode is given negative offsets. This catches a missing sign extension, an update on the wrong pointer, or a pre-increment that returns the old value. A load issued together with an increment of the same pointer shows whether the load has priority.

// File: rtl/bdag_pkg.sv
package bdag_pkg;

    // Indirect access mode codes carried on ind_op_i
    typedef enum logic [2:0] {
        IND_PLAIN   = 3'd0,
        IND_POSTINC = 3'd1,
        IND_POSTDEC = 3'd2,
        IND_PREINC  = 3'd3,
        IND_OFFSET  = 3'd4
    } ind_op_e;

endpackage

// File: rtl/bdag_direct.sv
module bdag_direct #(
    parameter int AW    = 12,
    parameter int OW    = 8,
    parameter int SPLIT = 96
) (
    input  logic [OW-1:0]    opnd_i,
    input  logic             acc_sel_i,
    input  logic [AW-OW-1:0] bank_i,
    input  logic             ext_en_i,
    input  logic [AW-1:0]    idx_base_i,
    output logic [AW-1:0]    addr_o
);
    localparam int BW = AW - OW;

    logic low_half;
    assign low_half = (opnd_i < OW'(SPLIT));

    always_comb begin
        if (acc_sel_i) begin
            addr_o = {bank_i, opnd_i};
        end else if (ext_en_i && low_half) begin
            addr_o = idx_base_i + {{BW{1'b0}}, opnd_i};
        end else if (low_half) begin
            addr_o = {{BW{1'b0}}, opnd_i};
        end else begin
            addr_o = {{BW{1'b1}}, opnd_i};
        end
    end
endmodule

// File: rtl/bdag_indirect.sv
module bdag_indirect
    import bdag_pkg::*;
#(
    parameter int AW = 12,
    parameter int OW = 8
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [2:0]    op_i,
    input  logic [OW-1:0] ofs_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] nxt_o,
    output logic          upd_o
);
    logic [AW-1:0] ofs_ext;
    assign ofs_ext = {{(AW-OW){ofs_i[OW-1]}}, ofs_i};

    always_comb begin
        addr_o = ptr_i;
        nxt_o  = ptr_i;
        upd_o  = 1'b0;
        case (op_i)
            IND_POSTINC: begin
                nxt_o = ptr_i + AW'(1);
                upd_o = 1'b1;
            end
            IND_POSTDEC: begin
                nxt_o = ptr_i - AW'(1);
                upd_o = 1'b1;
            end
            IND_PREINC: begin
                addr_o = ptr_i + AW'(1);
                nxt_o  = ptr_i + AW'(1);
                upd_o  = 1'b1;
            end
            IND_OFFSET: begin
                addr_o = ptr_i + ofs_ext;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bdag_ptr_file.sv
module bdag_ptr_file #(
    parameter int AW      = 12,
    parameter int NUM_PTR = 3,
    parameter int PW      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en_i,
    input  logic [PW-1:0]         ld_sel_i,
    input  logic [AW-1:0]         ld_val_i,
    input  logic                  upd_en_i,
    input  logic [PW-1:0]         upd_sel_i,
    input  logic [AW-1:0]         upd_val_i,
    output logic [NUM_PTR*AW-1:0] ptrs_o
);
    typedef struct packed {
        logic [NUM_PTR-1:0][AW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_PTR; k++) begin
            if (ld_en_i && (32'(ld_sel_i) == k)) begin
                st_d.ptr[k] = ld_val_i;
            end else if (upd_en_i && (32'(upd_sel_i) == k)) begin
                st_d.ptr[k] = upd_val_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_out
        assign ptrs_o[g*AW +: AW] = st_q.ptr[g];
    end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
    parameter int AW      = 12,
    parameter int OW      = 8,
    parameter int NUM_PTR = 3,
    parameter int SPLIT   = 96,
    localparam int BW     = AW - OW,
    localparam int PW     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OW-1:0]         opnd_i,
    input  logic                  acc_sel_i,
    input  logic [BW-1:0]         bank_i,
    input  logic                  ext_en_i,
    input  logic                  dest_bit_i,
    input  logic                  long_mv_i,
    input  logic [AW-1:0]         long_addr_i,
    input  logic                  ind_en_i,
    input  logic [PW-1:0]         ind_sel_i,
    input  logic [2:0]            ind_op_i,
    input  logic [OW-1:0]         ind_ofs_i,
    input  logic                  ld_en_i,
    input  logic [PW-1:0]         ld_sel_i,
    input  logic [AW-1:0]         ld_val_i,
    output logic [AW-1:0]         eff_addr_o,
    output logic                  dest_wreg_o,
    output logic [NUM_PTR*AW-1:0] ptrs_o
);
    localparam int IDX_PTR = NUM_PTR - 1;

    logic [AW-1:0] ptr_arr [NUM_PTR];
    logic [AW-1:0] ptr_sel;
    logic          sel_ok;
    logic [AW-1:0] dir_addr;
    logic [AW-1:0] ind_addr;
    logic [AW-1:0] ind_nxt;
    logic          ind_upd;
    logic          upd_en;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_unpack
        assign ptr_arr[g] = ptrs_o[g*AW +: AW];
    end

    assign sel_ok  = (32'(ind_sel_i) < NUM_PTR);
    assign ptr_sel = sel_ok ? ptr_arr[ind_sel_i] : '0;

    bdag_direct #(.AW(AW), .OW(OW), .SPLIT(SPLIT)) u_direct (
        .opnd_i     (opnd_i),
        .acc_sel_i  (acc_sel_i),
        .bank_i     (bank_i),
        .ext_en_i   (ext_en_i),
        .idx_base_i (ptr_arr[IDX_PTR]),
        .addr_o     (dir_addr)
    );

    bdag_indirect #(.AW(AW), .OW(OW)) u_indirect (
        .ptr_i  (ptr_sel),
        .op_i   (ind_op_i),
        .ofs_i  (ind_ofs_i),
        .addr_o (ind_addr),
        .nxt_o  (ind_nxt),
        .upd_o  (ind_upd)
    );

    assign upd_en = ind_en_i && ind_upd && sel_ok;

    bdag_ptr_file #(.AW(AW), .NUM_PTR(NUM_PTR), .PW(PW)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en_i   (ld_en_i),
        .ld_sel_i  (ld_sel_i),
        .ld_val_i  (ld_val_i),
        .upd_en_i  (upd_en),
        .upd_sel_i (ind_sel_i),
        .upd_val_i (ind_nxt),
        .ptrs_o    (ptrs_o)
    );

    always_comb begin
        if (ind_en_i) begin
            eff_addr_o = ind_addr;
        end else if (long_mv_i) begin
            eff_addr_o = long_addr_i;
        end else begin
            eff_addr_o = dir_addr;
        end
    end

    assign dest_wreg_o = ~dest_bit_i;
endmodule

// File: rtl/bdag_checker.sv
module bdag_checker #(
    parameter int AW      = 12,
    parameter int OW      = 8,
    parameter int NUM_PTR = 3,
    parameter int SPLIT   = 96,
    parameter int PW      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [OW-1:0]         opnd_i,
    input logic                  acc_sel_i,
    input logic [AW-OW-1:0]      bank_i,
    input logic                  long_mv_i,
    input logic [AW-1:0]         long_addr_i,
    input logic                  ind_en_i,
    input logic [PW-1:0]         ind_sel_i,
    input logic [2:0]            ind_op_i,
    input logic                  ld_en_i,
    input logic [PW-1:0]         ld_sel_i,
    input logic [AW-1:0]         ld_val_i,
    input logic [AW-1:0]         eff_addr_o,
    input logic [NUM_PTR*AW-1:0] ptrs_o
);
    function automatic logic [AW-1:0] pick(input logic [NUM_PTR*AW-1:0] flat,
                                           input logic [PW-1:0] s);
        return flat[32'(s)*AW +: AW];
    endfunction

    logic sel_ok, ld_ok, ld_hits_sel;
    assign sel_ok      = (32'(ind_sel_i) < NUM_PTR);
    assign ld_ok       = (32'(ld_sel_i) < NUM_PTR);
    assign ld_hits_sel = ld_en_i && (ld_sel_i == ind_sel_i);

    // R1
    a_r1_banked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind_en_i && !long_mv_i && acc_sel_i)
        |-> (eff_addr_o[AW-1:OW] == bank_i && eff_addr_o[OW-1:0] == opnd_i));

    // R4
    a_r4_upper_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind_en_i && !long_mv_i && !acc_sel_i && opnd_i >= OW'(SPLIT))
        |-> (eff_addr_o == {{(AW-OW){1'b1}}, opnd_i}));

    // R5
    a_r5_long_move: assert property (@(posedge clk) disable iff (!rst_n)
        (long_mv_i && !ind_en_i) |-> (eff_addr_o == long_addr_i));

    // R6, R9
    a_r6_postinc: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_en_i && sel_ok && ind_op_i == 3'd1 && !ld_hits_sel)
        |=> (pick(ptrs_o, $past(ind_sel_i)) == pick($past(ptrs_o), $past(ind_sel_i)) + AW'(1)));

    a_r6_postdec: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_en_i && sel_ok && ind_op_i == 3'd2 && !ld_hits_sel)
        |=> (pick(ptrs_o, $past(ind_sel_i)) == pick($past(ptrs_o), $past(ind_sel_i)) - AW'(1)));

    // R7
    a_r7_preinc_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_en_i && sel_ok && ind_op_i == 3'd3 && !ld_hits_sel)
        |=> (pick(ptrs_o, $past(ind_sel_i)) == $past(eff_addr_o)));

    // R8
    a_r8_offset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_en_i && sel_ok && ind_op_i == 3'd4 && !ld_hits_sel)
        |=> (pick(ptrs_o, $past(ind_sel_i)) == pick($past(ptrs_o), $past(ind_sel_i))));

    // R11
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en_i && ld_ok) |=> (pick(ptrs_o, $past(ld_sel_i)) == $past(ld_val_i)));

    // R12: with no load and no indirect access, no pointer moves
    a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en_i && !ind_en_i) |=> $stable(ptrs_o));
endmodule

bind bank_addr_gen bdag_checker #(
    .AW(AW), .OW(OW), .NUM_PTR(NUM_PTR), .SPLIT(SPLIT), .PW(PW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opnd_i      (opnd_i),
    .acc_sel_i   (acc_sel_i),
    .bank_i      (bank_i),
    .long_mv_i   (long_mv_i),
    .long_addr_i (long_addr_i),
    .ind_en_i    (ind_en_i),
    .ind_sel_i   (ind_sel_i),
    .ind_op_i    (ind_op_i),
    .ld_en_i     (ld_en_i),
    .ld_sel_i    (ld_sel_i),
    .ld_val_i    (ld_val_i),
    .eff_addr_o  (eff_addr_o),
    .ptrs_o      (ptrs_o)
);

// File: tb/bank_addr_gen_tb.sv
module bank_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  opnd;
    logic        acc_sel;
    logic [3:0]  bank;
    logic        ext_en;
    logic        dest_bit;
    logic        long_mv;
    logic [11:0] long_addr;
    logic        ind_en;
    logic [1:0]  ind_sel;
    logic [2:0]  ind_op;
    logic [7:0]  ind_ofs;
    logic        ld_en;
    logic [1:0]  ld_sel;
    logic [11:0] ld_val;
    logic [11:0] eff_addr;
    logic        dest_wreg;
    logic [35:0] ptrs;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd), .acc_sel_i(acc_sel), .bank_i(bank),
        .ext_en_i(ext_en), .dest_bit_i(dest_bit), .long_mv_i(long_mv),
        .long_addr_i(long_addr), .ind_en_i(ind_en), .ind_sel_i(ind_sel),
        .ind_op_i(ind_op), .ind_ofs_i(ind_ofs), .ld_en_i(ld_en), .ld_sel_i(ld_sel),
        .ld_val_i(ld_val), .eff_addr_o(eff_addr), .dest_wreg_o(dest_wreg), .ptrs_o(ptrs)
    );

    function automatic logic [11:0] ptr_of(input int k);
        return ptrs[k*12 +: 12];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_dir(input logic [7:0] o, input logic a,
                                            input logic [3:0] b, input logic e,
                                            input logic [11:0] p2);
        if (a)                    return {b, o};
        else if (e && o < 8'h60)  return p2 + {4'h0, o};
        else if (o < 8'h60)       return {4'h0, o};
        else                      return {4'hF, o};
    endfunction

    task automatic idle();
        opnd = 0; acc_sel = 0; bank = 0; ext_en = 0; dest_bit = 0;
        long_mv = 0; long_addr = 0; ind_en = 0; ind_sel = 0; ind_op = 0;
        ind_ofs = 0; ld_en = 0; ld_sel = 0; ld_val = 0;
    endtask

    task automatic load(input int k, input logic [11:0] v);
        @(negedge clk);
        ld_en = 1; ld_sel = 2'(k); ld_val = v;
        @(negedge clk);
        ld_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] p0s, p1s;
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) chk("R11 reset value", 32'(ptr_of(k)), 0);
        rst_n = 1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) chk("R11 after reset", 32'(ptr_of(k)), 0);

        // Pointer loads
        load(0, 12'h123); load(1, 12'hFFF); load(2, 12'h0F0);
        chk("R11 load p0", 32'(ptr_of(0)), 32'h123);
        chk("R11 load p1", 32'(ptr_of(1)), 32'hFFF);
        chk("R11 load p2", 32'(ptr_of(2)), 32'h0F0);

        // Direct sweep: R1 R2 R3 R4 R10
        for (int e = 0; e < 2; e++)
            for (int a = 0; a < 2; a++)
                for (int b = 0; b < 16; b += 5)
                    for (int o = 0; o < 256; o++) begin
                        @(negedge clk);
                        ext_en = e[0]; acc_sel = a[0]; bank = 4'(b); opnd = 8'(o);
                        dest_bit = o[0];
                        #1;
                        if (a == 1)           chk("R1 banked", 32'(eff_addr), 32'(exp_dir(8'(o), 1'b1, 4'(b), e[0], 12'h0F0)));
                        else if (e == 0)      chk("R2 access bank", 32'(eff_addr), 32'(exp_dir(8'(o), 1'b0, 4'(b), 1'b0, 12'h0F0)));
                        else if (o < 'h60)    chk("R3 indexed", 32'(eff_addr), 32'(exp_dir(8'(o), 1'b0, 4'(b), 1'b1, 12'h0F0)));
                        else                  chk("R4 upper with ext", 32'(eff_addr), 32'(exp_dir(8'(o), 1'b0, 4'(b), 1'b1, 12'h0F0)));
                        chk("R10 dest", 32'(dest_wreg), 32'(~o[0] & 1));
                    end
        @(negedge clk);
        chk("R12 p0 untouched by ext", 32'(ptr_of(0)), 32'h123);
        chk("R12 p1 untouched by ext", 32'(ptr_of(1)), 32'hFFF);

        // R3 wrap of indexed sum
        idle();
        load(2, 12'hFC0);
        ext_en = 1; acc_sel = 0; opnd = 8'h5F; #1;
        chk("R3 indexed wrap", 32'(eff_addr), 32'h01F);
        opnd = 8'h60; #1;
        chk("R4 boundary 0x60", 32'(eff_addr), 32'hF60);

        // R5 long moves ignore bank and access bit
        idle();
        foreach (long_addr[i]) ;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            long_mv = 1; long_addr = 12'(j * 12'h555 + 12'h0AB);
            bank = 4'(j * 3); acc_sel = j[0]; ext_en = j[1]; opnd = 8'(j * 40);
            #1;
            chk("R5 long move", 32'(eff_addr), 32'(12'(j * 12'h555 + 12'h0AB)));
        end
        // R6 indirect wins over long move
        ind_en = 1; ind_sel = 0; ind_op = 0; #1;
        chk("R6 indirect priority", 32'(eff_addr), 32'h123);
        idle();

        // Indirect modes R6 R7 R8 R9 R12
        for (int k = 0; k < 3; k++)
            for (int op = 0; op < 8; op++)
                for (int bi = 0; bi < 3; bi++)
                    for (int oi = 0; oi < 4; oi++) begin
                        logic [11:0] base, ea, en, ofsx;
                        logic [7:0] ofs;
                        base = (bi == 0) ? 12'h000 : (bi == 1) ? 12'h7FF : 12'hFFF;
                        ofs  = (oi == 0) ? 8'h00 : (oi == 1) ? 8'h7F : (oi == 2) ? 8'h80 : 8'hFF;
                        ofsx = {{4{ofs[7]}}, ofs};
                        ea = base; en = base;
                        case (op)
                            1: en = base + 12'd1;
                            2: en = base - 12'd1;
                            3: begin ea = base + 12'd1; en = base + 12'd1; end
                            4: ea = base + ofsx;
                            default: ;
                        endcase
                        load(k, base);
                        p0s = ptr_of((k + 1) % 3);
                        p1s = ptr_of((k + 2) % 3);
                        ind_en = 1; ind_sel = 2'(k); ind_op = 3'(op); ind_ofs = ofs;
                        long_mv = 1; long_addr = 12'hABC;
                        #1;
                        if (op == 3)      chk("R7 preinc addr", 32'(eff_addr), 32'(ea));
                        else if (op == 4) chk("R8 offset addr", 32'(eff_addr), 32'(ea));
                        else              chk("R6 indirect addr", 32'(eff_addr), 32'(ea));
                        @(negedge clk);
                        ind_en = 0; long_mv = 0;
                        if (op == 3)      chk("R7 preinc ptr", 32'(ptr_of(k)), 32'(en));
                        else if (op >= 4) chk("R8 ptr held", 32'(ptr_of(k)), 32'(en));
                        else              chk("R9 R6 ptr update", 32'(ptr_of(k)), 32'(en));
                        chk("R12 other ptr a", 32'(ptr_of((k + 1) % 3)), 32'(p0s));
                        chk("R12 other ptr b", 32'(ptr_of((k + 2) % 3)), 32'(p1s));
                    end

        // R11 load wins over same-cycle update
        load(1, 12'h010);
        @(negedge clk);
        ind_en = 1; ind_sel = 1; ind_op = 3'd1; ld_en = 1; ld_sel = 1; ld_val = 12'h3A5;
        @(negedge clk);
        idle();
        chk("R11 load beats postinc", 32'(ptr_of(1)), 32'h3A5);
        // load on one pointer, update on another in same cycle
        @(negedge clk);
        ind_en = 1; ind_sel = 1; ind_op = 3'd2; ld_en = 1; ld_sel = 0; ld_val = 12'h777;
        @(negedge clk);
        idle();
        chk("R11 load other ptr", 32'(ptr_of(0)), 32'h777);
        chk("R6 dec alongside load", 32'(ptr_of(1)), 32'h3A4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule